// File: doc/BRIEF.md
# Ordered Store Drain Through Line Fill Buffers

This block takes stores off the head of a store queue and decides how each one reaches the L1 data array. A store to a line the cache already owns goes straight to the array when nothing older is waiting. A store that misses is placed in a line fill buffer (LFB) that requests ownership (an RFO) for its cache line. Back-to-back missing stores to the same line are folded into one LFB. Several RFOs can be outstanding at once, and the block still keeps program order. It records the order in which LFBs were opened. It writes their merged bytes into the array strictly in that order, one LFB per cycle, after each one's ownership has arrived.

The store queue head uses a valid/ready handshake. `st_valid` may be held for any number of cycles. The queue keeps the store stable until `st_ready` is seen high at a clock edge. The block drops `st_ready` to stall a store that cannot be placed safely. The RFO request is also valid/ready: `rfo_valid`, `rfo_line` and `rfo_id` stay put until `rfo_ready` is high. Grant responses (`fill_valid`) and array writes (`wr_valid`) are plain one-cycle strobes with no back-pressure.

Top module: `lfb_store_drain`

## Requirements
- R1: After reset, all LFBs are free, and `rfo_valid` and `wr_valid` are low. With `st_valid` low, `st_ready` is low.
- R2: A store with `st_hit` high is accepted when no LFB is open. One cycle later, `wr_valid` pulses with the store's line. Byte k of the store sits at line byte `st_widx*8+k`: `wr_data` holds the data word there, and `wr_mask` holds `st_be` there.
- R3: A store to a line that matches no open LFB opens the lowest-numbered free LFB, if one is free, and is accepted in the same cycle.
- R4: A store whose line matches the most recently opened LFB merges into that LFB. Bytes written later replace earlier bytes, and the byte mask accumulates.
- R5: A store whose line matches an open LFB other than the most recently opened one is not accepted. It waits until that LFB has been written to the array.
- R6: When all LFBs are busy and the store matches none of them, the store is not accepted.
- R7: An LFB is written to the array only when it is the oldest open LFB and its grant has arrived. This holds even when grants arrive out of order. At most one LFB is written per cycle, and `wr_valid` follows the commit decision by one cycle.
- R8: A store with `st_hit` high that arrives while any LFB is open does not go to the array directly. It merges into the newest LFB, or opens an LFB that needs no RFO and is ready to commit at once.
- R9: A store that matches the newest LFB is stalled in the cycle where that same LFB is being committed.
- R10: The RFO request names the lowest-numbered LFB that still needs to issue its RFO, together with that LFB's line. An LFB opened by a miss raises its request in the cycle after it is opened, and several RFOs may be outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store queue head holds a store |
| st_ready | output | 1 | Head store accepted this cycle |
| st_line | input | LINE_W | Line address of the store |
| st_widx | input | WIDX_W | Word index within the line |
| st_data | input | WORD_BYTES*8 | Store data word |
| st_be | input | WORD_BYTES | Byte enables within the word |
| st_hit | input | 1 | Line already owned in the L1 |
| rfo_valid | output | 1 | Ownership request pending |
| rfo_ready | input | 1 | Request accepted by transport |
| rfo_line | output | LINE_W | Line being requested |
| rfo_id | output | ID_W | LFB tag of the request |
| fill_valid | input | 1 | Ownership granted for one LFB |
| fill_id | input | ID_W | LFB tag of the grant |
| wr_valid | output | 1 | Array write strobe |
| wr_line | output | LINE_W | Line written |
| wr_data | output | LINE_BYTES*8 | Line-wide write data |
| wr_mask | output | LINE_BYTES | Per-byte write enables |

## Verification
Acceptance (`st_ready`) is combinational, so it is compared about 1 ns after the inputs change in the same cycle. The RFO request appears one cycle after the store that opened the LFB was accepted. Array writes come one cycle after the commit decision or the direct-write acceptance. A commit can happen no earlier than the cycle after a grant. The bench model holds the expected registered write from the previous edge and compares it at the next falling edge, before new inputs are driven. Grants are returned with line-dependent delays, so later LFBs often become ready before older ones.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE,
    SLOT_RFO,
    SLOT_WAIT,
    SLOT_READY
  } slot_st_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_DIRECT,
    ACT_MERGE,
    ACT_OPEN
  } act_e;
endpackage

// File: rtl/lfb_pick.sv
module lfb_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lfb_age_queue.sv
module lfb_age_queue #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [IW-1:0] push_id_i,
  input  logic          pop_i,
  output logic [IW-1:0] head_o,
  output logic [IW-1:0] tail_o,
  output logic          empty_o
);
  logic [IW-1:0] ids_q [N];
  logic [IW-1:0] rd_q, wr_q, last_ptr;
  logic [IW:0]   cnt_q;
  logic          full;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  assign last_ptr = (wr_q == '0) ? IW'(N - 1) : wr_q - 1'b1;
  assign head_o   = ids_q[rd_q];
  assign tail_o   = ids_q[last_ptr];
  assign empty_o  = (cnt_q == '0);
  assign full     = (cnt_q == (IW + 1)'(N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < N; i++) ids_q[i] <= '0;
    end else begin
      if (push_i) begin
        ids_q[wr_q] <= push_id_i;
        wr_q        <= bump(wr_q);
      end
      if (pop_i) rd_q <= bump(rd_q);
      cnt_q <= cnt_q + (IW + 1)'(push_i) - (IW + 1)'(pop_i);
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full);
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
  // R7
  one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lfb_slot.sv
module lfb_slot
  import lfb_pkg::*;
#(
  parameter int LW = 26,
  parameter int LB = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            open_i,
  input  logic            open_hit_i,
  input  logic            merge_i,
  input  logic            free_i,
  input  logic            rfo_take_i,
  input  logic            fill_i,
  input  logic [LW-1:0]   line_i,
  input  logic [LB*8-1:0] wdata_i,
  input  logic [LB-1:0]   wmask_i,
  output slot_st_e        state_o,
  output logic [LW-1:0]   line_o,
  output logic [LB*8-1:0] data_o,
  output logic [LB-1:0]   mask_o
);
  slot_st_e st_q;

  assign state_o = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SLOT_IDLE;
    end else if (free_i) begin
      st_q <= SLOT_IDLE;
    end else if (open_i) begin
      st_q <= open_hit_i ? SLOT_READY : SLOT_RFO;
    end else if (rfo_take_i && st_q == SLOT_RFO) begin
      st_q <= SLOT_WAIT;
    end else if (fill_i && st_q == SLOT_WAIT) begin
      st_q <= SLOT_READY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_o <= '0;
      data_o <= '0;
      mask_o <= '0;
    end else if (open_i) begin
      line_o <= line_i;
      data_o <= wdata_i;
      mask_o <= wmask_i;
    end else if (merge_i) begin
      for (int b = 0; b < LB; b++) begin
        if (wmask_i[b]) data_o[b*8 +: 8] <= wdata_i[b*8 +: 8];
      end
      mask_o <= mask_o | wmask_i;
    end
  end

  // R3
  open_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_i |-> st_q == SLOT_IDLE);
  // R4
  merge_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merge_i |-> st_q != SLOT_IDLE);
endmodule

// File: rtl/lfb_store_drain.sv
module lfb_store_drain
  import lfb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int NUM_LFB    = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int WIDX_W    = $clog2(LINE_BYTES / WORD_BYTES),
  localparam int ID_W      = $clog2(NUM_LFB),
  localparam int WORD_BITS = WORD_BYTES * 8,
  localparam int LINE_BITS = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  output logic                  st_ready,
  input  logic [LINE_W-1:0]     st_line,
  input  logic [WIDX_W-1:0]     st_widx,
  input  logic [WORD_BITS-1:0]  st_data,
  input  logic [WORD_BYTES-1:0] st_be,
  input  logic                  st_hit,
  output logic                  rfo_valid,
  input  logic                  rfo_ready,
  output logic [LINE_W-1:0]     rfo_line,
  output logic [ID_W-1:0]       rfo_id,
  input  logic                  fill_valid,
  input  logic [ID_W-1:0]       fill_id,
  output logic                  wr_valid,
  output logic [LINE_W-1:0]     wr_line,
  output logic [LINE_BITS-1:0]  wr_data,
  output logic [LINE_BYTES-1:0] wr_mask
);
  logic [LINE_BITS-1:0]  st_wdata;
  logic [LINE_BYTES-1:0] st_wmask;

  slot_st_e                           slot_st   [NUM_LFB];
  logic [NUM_LFB-1:0][LINE_W-1:0]     slot_line;
  logic [NUM_LFB-1:0][LINE_BITS-1:0]  slot_data;
  logic [NUM_LFB-1:0][LINE_BYTES-1:0] slot_mask;
  logic [NUM_LFB-1:0] busy, idle, match, need, newest_oh;

  logic [ID_W-1:0] oldest_id, newest_id, free_id;
  logic            q_empty, free_any, commit_go, stale, match_newest;
  act_e            act;

  // Place the word at its byte offset inside the line.
  assign st_wdata = LINE_BITS'(st_data) << (32'(st_widx) * WORD_BITS);
  assign st_wmask = LINE_BYTES'(st_be) << (32'(st_widx) * WORD_BYTES);

  for (genvar g = 0; g < NUM_LFB; g++) begin : g_slot
    lfb_slot #(.LW(LINE_W), .LB(LINE_BYTES)) i_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_i     (act == ACT_OPEN && free_id == ID_W'(g)),
      .open_hit_i (st_hit),
      .merge_i    (act == ACT_MERGE && newest_id == ID_W'(g)),
      .free_i     (commit_go && oldest_id == ID_W'(g)),
      .rfo_take_i (rfo_valid && rfo_ready && rfo_id == ID_W'(g)),
      .fill_i     (fill_valid && fill_id == ID_W'(g)),
      .line_i     (st_line),
      .wdata_i    (st_wdata),
      .wmask_i    (st_wmask),
      .state_o    (slot_st[g]),
      .line_o     (slot_line[g]),
      .data_o     (slot_data[g]),
      .mask_o     (slot_mask[g])
    );
    assign busy[g]  = (slot_st[g] != SLOT_IDLE);
    assign idle[g]  = !busy[g];
    assign match[g] = busy[g] && (slot_line[g] == st_line);
    assign need[g]  = (slot_st[g] == SLOT_RFO);
  end

  lfb_age_queue #(.N(NUM_LFB), .IW(ID_W)) i_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (act == ACT_OPEN),
    .push_id_i (free_id),
    .pop_i     (commit_go),
    .head_o    (oldest_id),
    .tail_o    (newest_id),
    .empty_o   (q_empty)
  );

  lfb_pick #(.N(NUM_LFB), .IW(ID_W)) i_free_pick (
    .req_i (idle),
    .any_o (free_any),
    .idx_o (free_id)
  );

  lfb_pick #(.N(NUM_LFB), .IW(ID_W)) i_rfo_pick (
    .req_i (need),
    .any_o (rfo_valid),
    .idx_o (rfo_id)
  );

  assign rfo_line     = slot_line[rfo_id];
  assign commit_go    = !q_empty && (slot_st[oldest_id] == SLOT_READY);
  assign newest_oh    = q_empty ? '0 : (NUM_LFB'(1) << newest_id);
  assign match_newest = |(match & newest_oh);
  assign stale        = |(match & ~newest_oh);

  always_comb begin
    act = ACT_NONE;
    if (st_valid) begin
      if (q_empty && st_hit) begin
        act = ACT_DIRECT;
      end else if (stale) begin
        act = ACT_NONE;
      end else if (match_newest) begin
        if (!(commit_go && oldest_id == newest_id)) act = ACT_MERGE;
      end else if (free_any) begin
        act = ACT_OPEN;
      end
    end
  end

  assign st_ready = (act != ACT_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_line  <= '0;
      wr_data  <= '0;
      wr_mask  <= '0;
    end else if (commit_go) begin
      wr_valid <= 1'b1;
      wr_line  <= slot_line[oldest_id];
      wr_data  <= slot_data[oldest_id];
      wr_mask  <= slot_mask[oldest_id];
    end else if (act == ACT_DIRECT) begin
      wr_valid <= 1'b1;
      wr_line  <= st_line;
      wr_data  <= st_wdata;
      wr_mask  <= st_wmask;
    end else begin
      wr_valid <= 1'b0;
    end
  end

  // R2
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && st_hit && q_empty) |=>
      (wr_valid && wr_line == $past(st_line)));
  // R5
  stale_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && stale) |-> !st_ready);
  // R8
  no_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && !q_empty) |=> $past(commit_go) || !wr_valid);
endmodule

// File: tb/test_lfb_store_drain.sv
module test_lfb_store_drain;
  localparam int LW = 26;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic st_valid, st_ready, st_hit;
  logic [LW-1:0] st_line;
  logic [2:0] st_widx;
  logic [63:0] st_data;
  logic [7:0] st_be;
  logic rfo_valid, rfo_ready;
  logic [LW-1:0] rfo_line;
  logic [1:0] rfo_id;
  logic fill_valid;
  logic [1:0] fill_id;
  logic wr_valid;
  logic [LW-1:0] wr_line;
  logic [511:0] wr_data;
  logic [63:0] wr_mask;

  lfb_store_drain i_lfb_store_drain (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_line(st_line),
    .st_widx(st_widx), .st_data(st_data), .st_be(st_be), .st_hit(st_hit),
    .rfo_valid(rfo_valid), .rfo_ready(rfo_ready), .rfo_line(rfo_line),
    .rfo_id(rfo_id), .fill_valid(fill_valid), .fill_id(fill_id),
    .wr_valid(wr_valid), .wr_line(wr_line), .wr_data(wr_data),
    .wr_mask(wr_mask)
  );

  always #10 clk = ~clk;

  typedef struct {
    int gap; logic [LW-1:0] line; int widx;
    logic [63:0] data; logic [7:0] be; bit hit;
  } st_t;

  st_t sq[$];
  int  fq_id[$];
  int  fq_t[$];

  int m_st[NL];
  logic [LW-1:0] m_line[NL];
  logic [511:0] m_data[NL];
  logic [63:0] m_mask[NL];
  int ord[$];

  bit e_wv;
  logic [LW-1:0] e_wl;
  logic [511:0] e_wd;
  logic [63:0] e_wm;
  string e_tag;

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic chk(bit ok, string tag, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic add(int gap, int line, int widx, logic [63:0] d, logic [7:0] be, bit hit);
    st_t s;
    s.gap = gap; s.line = LW'(line); s.widx = widx;
    s.data = d; s.be = be; s.hit = hit;
    sq.push_back(s);
  endtask

  function automatic int fdelay(logic [LW-1:0] l);
    return ((int'(l) * 5) % 7) + 1;
  endfunction

  initial begin
    rst_n = 1'b0; st_valid = 0; st_hit = 0; st_line = '0; st_widx = '0;
    st_data = '0; st_be = '0; rfo_ready = 0; fill_valid = 0; fill_id = '0;
    for (int i = 0; i < NL; i++) begin
      m_st[i] = 0; m_line[i] = '0; m_data[i] = '0; m_mask[i] = '0;
    end
    e_wv = 0; e_tag = "R7";

    // R2 direct writes with nothing open
    add(0, 5, 0, 64'h1111_2222_3333_4444, 8'hff, 1);
    add(0, 5, 3, 64'haaaa_bbbb_cccc_dddd, 8'h0f, 1);
    // R4 run of A A A B B C C C C with overwrite
    add(2, 10, 0, 64'h0101_0101_0101_0101, 8'hff, 0);
    add(0, 10, 0, 64'h0202_0202_0202_0202, 8'h0f, 0);
    add(0, 10, 7, 64'h0303_0303_0303_0303, 8'hf0, 0);
    add(0, 11, 1, 64'h0404_0404_0404_0404, 8'hff, 0);
    add(0, 11, 2, 64'h0505_0505_0505_0505, 8'h3c, 0);
    add(0, 12, 4, 64'h0606_0606_0606_0606, 8'hff, 0);
    add(0, 12, 4, 64'h0707_0707_0707_0707, 8'h01, 0);
    add(0, 12, 5, 64'h0808_0808_0808_0808, 8'h80, 0);
    add(0, 12, 6, 64'h0909_0909_0909_0909, 8'hff, 0);
    // R5 pattern A B A
    add(30, 20, 0, 64'h1234, 8'h03, 0);
    add(0, 21, 1, 64'h5678, 8'h0c, 0);
    add(0, 20, 2, 64'h9abc, 8'hff, 0);
    // R6 five distinct lines
    add(30, 30, 0, 64'h30, 8'h01, 0);
    add(0, 31, 1, 64'h31, 8'h01, 0);
    add(0, 32, 2, 64'h32, 8'h01, 0);
    add(0, 33, 3, 64'h33, 8'h01, 0);
    add(0, 34, 4, 64'h34, 8'h01, 0);
    // R8 hits while something is open, then a direct hit
    add(30, 40, 0, 64'h40, 8'hff, 0);
    add(0, 41, 1, 64'h41, 8'hff, 1);
    add(0, 41, 2, 64'h42, 8'hff, 1);
    add(30, 42, 3, 64'h43, 8'hff, 1);
    // R9 sweep: miss then repeat store to the same line at varying gaps
    for (int g = 1; g < 14; g++) begin
      add(20, 50 + g, 0, 64'(g), 8'h0f, 0);
      add(g, 50 + g, 1, 64'(g * 3), 8'hf0, 0);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(rfo_valid == 0, "R1 rfo_valid", 512'(rfo_valid), 0);
    chk(wr_valid == 0, "R1 wr_valid", 512'(wr_valid), 0);
    chk(st_ready == 0, "R1 st_ready", 512'(st_ready), 0);

    forever begin
      int act, fid, rid, oldest, newest, freeid;
      bit commit, stale, mnew, freeany, rv, take;
      logic [511:0] wd;
      logic [63:0] wm;
      string rtag;

      @(negedge clk);
      cyc++;
      // registered write from the previous edge
      chk(wr_valid === e_wv, {e_tag, " wr_valid"}, 512'(wr_valid), 512'(e_wv));
      if (e_wv) begin
        chk(wr_line === e_wl, {e_tag, " wr_line"}, 512'(wr_line), 512'(e_wl));
        chk(wr_data === e_wd, {e_tag, " wr_data"}, wr_data, e_wd);
        chk(wr_mask === e_wm, {e_tag, " wr_mask"}, 512'(wr_mask), 512'(e_wm));
      end

      if (sq.size() == 0 && ord.size() == 0 && fq_id.size() == 0 && !e_wv) break;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        break;
      end

      // drive inputs
      st_valid = 0;
      if (sq.size() > 0) begin
        if (sq[0].gap > 0) sq[0].gap = sq[0].gap - 1;
        else begin
          st_valid = 1; st_line = sq[0].line; st_widx = 3'(sq[0].widx);
          st_data = sq[0].data; st_be = sq[0].be; st_hit = sq[0].hit;
        end
      end
      rfo_ready = (cyc % 5) != 4;
      fill_valid = 0; fid = -1;
      for (int k = 0; k < fq_id.size(); k++) begin
        if (fq_t[k] <= 0) begin
          fid = fq_id[k]; fq_id.delete(k); fq_t.delete(k); break;
        end
      end
      for (int k = 0; k < fq_t.size(); k++) fq_t[k] = fq_t[k] - 1;
      if (fid >= 0) begin fill_valid = 1; fill_id = 2'(fid); end
      #1;

      // model decision
      wd = 512'(st_data) << (int'(st_widx) * 64);
      wm = 64'(st_be) << (int'(st_widx) * 8);
      commit = ord.size() > 0 && m_st[ord[0]] == 3;
      oldest = ord.size() > 0 ? ord[0] : -1;
      newest = ord.size() > 0 ? ord[ord.size() - 1] : -1;
      stale = 0; mnew = 0; freeany = 0; freeid = 0;
      for (int i = NL - 1; i >= 0; i--) begin
        if (m_st[i] == 0) begin freeany = 1; freeid = i; end
        else if (m_line[i] == st_line) begin
          if (i == newest) mnew = 1; else stale = 1;
        end
      end
      act = 0; rtag = "R1";
      if (st_valid) begin
        if (ord.size() == 0 && st_hit) begin act = 1; rtag = "R2"; end
        else if (stale) rtag = "R5";
        else if (mnew) begin
          if (commit && oldest == newest) rtag = "R9";
          else begin act = 2; rtag = "R4"; end
        end else if (freeany) begin act = 3; rtag = st_hit ? "R8" : "R3"; end
        else rtag = "R6";
      end
      chk(st_ready === (act != 0), {rtag, " st_ready"}, 512'(st_ready), 512'(act != 0));
      rv = 0; rid = 0;
      for (int i = NL - 1; i >= 0; i--) if (m_st[i] == 1) begin rv = 1; rid = i; end
      chk(rfo_valid === rv, "R10 rfo_valid", 512'(rfo_valid), 512'(rv));
      if (rv) begin
        chk(rfo_id === 2'(rid), "R10 rfo_id", 512'(rfo_id), 512'(rid));
        chk(rfo_line === m_line[rid], "R10 rfo_line", 512'(rfo_line), 512'(m_line[rid]));
      end
      take = rv && rfo_ready;

      // model next state
      e_wv = 0;
      if (commit) begin
        e_wv = 1; e_tag = "R7";
        e_wl = m_line[oldest]; e_wd = m_data[oldest]; e_wm = m_mask[oldest];
        m_st[oldest] = 0; void'(ord.pop_front());
      end
      if (act == 1) begin
        e_wv = 1; e_tag = "R2"; e_wl = st_line; e_wd = wd; e_wm = wm;
      end else if (act == 2) begin
        for (int b = 0; b < 64; b++) if (wm[b]) m_data[newest][b*8 +: 8] = wd[b*8 +: 8];
        m_mask[newest] = m_mask[newest] | wm;
      end else if (act == 3) begin
        m_st[freeid] = st_hit ? 3 : 1; m_line[freeid] = st_line;
        m_data[freeid] = wd; m_mask[freeid] = wm; ord.push_back(freeid);
      end
      if (take) begin
        m_st[rid] = 2; fq_id.push_back(rid); fq_t.push_back(fdelay(m_line[rid]));
      end
      if (fid >= 0 && m_st[fid] == 2) m_st[fid] = 3;
      if (act != 0) void'(sq.pop_front());
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule